// File: doc/BRIEF.md
# Motor Control PWM Generator

This block produces pulse-width modulated drive for a motor bridge. One shared time base counts clock cycles. Four duty comparators measure it, and each comparator drives a pair of pins: a high-side pin and a low-side pin. Each pair works in one of two ways. In complementary mode the low pin is the inverse of the high pin, and a programmable dead band keeps the two pins from being active together. In independent mode both pins follow the comparator directly. The time base counts in one of two ways. In edge-aligned mode it counts up and wraps. In center-aligned mode it counts up to the period and then back down.

Software configures the block through a simple write port. Period and duty values are written into shadow registers. These take effect only when the counter reaches zero, so a pulse is never cut short in the middle of a period. Each pin can be inverted, and each pin can be forced to a fixed level by a manual override. A one-cycle trigger pulse starts an analog-to-digital conversion at a chosen count. In center-aligned mode the trigger can be restricted to the rising or the falling half of the period.

Top module: `mcpwm_core`

## Requirements
- R1: Edge-aligned mode (address 2 bit 0 = 0): the counter runs 0,1,...,P and then wraps to 0, where P is the period written at address 0. A full period is therefore P+1 cycles.
- R2: Center-aligned mode (address 2 bit 0 = 1): the counter runs 0 up to P and back down to 1 before it returns to 0. A full period is therefore 2P cycles.
- R3: A pair's comparator output is active while the counter is below that pair's duty value. Pair i's duty is at address 8+i. A duty of 0 is never active, and a duty of P+1 or more is always active.
- R4: Complementary mode (address 2 bit 1+i = 0 for pair i): the low pin carries the inverse of the comparator. Each active run of either pin begins D cycles late, where D is address 1 bits 5:0. A run of D cycles or fewer is suppressed entirely. An output that is active for the whole period is not shortened. The two pins of a pair are never active together.
- R5: Independent mode (address 2 bit 1+i = 1): both pins of pair i carry the comparator output with no dead band. After reset, all pairs are independent.
- R6: Polarity (address 3): bit i inverts high pin i and bit 4+i inverts low pin i. A pin with its bit set is active low.
- R7: Manual override (address 4): bit i forces high pin i and bit 4+i forces low pin i. The forced level is taken from bit 8+i and bit 12+i respectively, is applied to the pin as written, and ignores both polarity and the comparator.
- R8: Period, duty values and the counting mode are taken from their shadow registers only when the counter returns to 0. A duty written in the middle of a period leaves the pin unchanged until the next zero.
- R9: The trigger output pulses for one cycle once per period, on the cycle after the counter equals the compare value (address 5 bits 14:0). It does not pulse if the compare value exceeds P. After reset the compare value is all ones.
- R10: In center-aligned mode, address 5 bit 15 = 0 selects the up-count pass, which includes the counts 0 and P. Bit 15 = 1 selects the down-count pass, counts 1 to P-1. In edge-aligned mode bit 15 is ignored.
- R11: While reset is held, and after it is released with no writes, all pins and the trigger are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| pwm_hi | output | 4 | High-side pins, one per pair |
| pwm_lo | output | 4 | Low-side pins, one per pair |
| adc_trig | output | 1 | One-cycle conversion start pulse |

## Verification
The trigger compare value and the shadow reload can both fall on count zero. At that cycle the new period and duty take effect, and in the same cycle the trigger must fire exactly once. The sweep reaches this case whenever the compare value is 0 and new settings are written. It is judged by two measurements over a window of exactly two new periods: the number of trigger pulses, and each pin's active-cycle count, which must match the new period rather than the old one. The override also competes with a comparator that is always active. Pins forced low while their duty is above the period must stay low for the whole window.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;
  localparam int ADDR_W = 4;
  typedef enum logic [ADDR_W-1:0] {
    A_PERIOD = 4'd0,
    A_DEAD   = 4'd1,
    A_MODE   = 4'd2,
    A_POL    = 4'd3,
    A_OVR    = 4'd4,
    A_TRIG   = 4'd5
  } reg_addr_e;
  localparam int DUTY_BASE = 8;
endpackage

// File: rtl/mcpwm_timebase.sv
module mcpwm_timebase #(
  parameter int CNT_W = 15,
  parameter int NPAIR = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [CNT_W-1:0]             per_sh,
  input  logic                         center_sh,
  input  logic [NPAIR-1:0][CNT_W-1:0]  duty_sh,
  output logic [CNT_W-1:0]             cnt_o,
  output logic                         up_o,
  output logic                         center_o,
  output logic [CNT_W-1:0]             per_o,
  output logic [NPAIR-1:0][CNT_W-1:0]  duty_o
);
  logic [CNT_W-1:0] cnt_nx;
  logic             up_nx;
  logic             reload;

  always_comb begin
    cnt_nx = cnt_o;
    up_nx  = up_o;
    if (!center_o) begin
      up_nx = 1'b1;
      if (cnt_o >= per_o) cnt_nx = '0;
      else                cnt_nx = cnt_o + 1'b1;
    end else if (per_o == '0) begin
      cnt_nx = '0;
    end else if (up_o) begin
      if (cnt_o >= per_o) begin
        cnt_nx = per_o - 1'b1;
        up_nx  = 1'b0;
      end else begin
        cnt_nx = cnt_o + 1'b1;
      end
    end else begin
      cnt_nx = cnt_o - 1'b1;
    end
    if (cnt_nx == '0) up_nx = 1'b1;
    reload = (cnt_nx == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o    <= '0;
      up_o     <= 1'b1;
      center_o <= 1'b0;
      per_o    <= '0;
      duty_o   <= '0;
    end else begin
      cnt_o <= cnt_nx;
      up_o  <= up_nx;
      if (reload) begin
        per_o    <= per_sh;
        center_o <= center_sh;
        duty_o   <= duty_sh;
      end
    end
  end
endmodule

// File: rtl/mcpwm_deadband.sv
module mcpwm_deadband #(
  parameter int DT_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            out_o
);
  logic [DT_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || !in_i)        run_q <= '0;
    else if (run_q < dead_i) run_q <= run_q + 1'b1;
  end

  assign out_o = in_i && (run_q >= dead_i);
endmodule

// File: rtl/mcpwm_trigger.sv
module mcpwm_trigger #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             up_i,
  input  logic             center_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             down_sel_i,
  output logic             trig_o
);
  logic hit;
  assign hit = (cnt_i == cmp_i) && (!center_i || (up_i != down_sel_i));

  always_ff @(posedge clk) begin
    if (rst) trig_o <= 1'b0;
    else     trig_o <= hit;
  end
endmodule

// File: rtl/mcpwm_core.sv
module mcpwm_core #(
  parameter int CNT_W  = 15,
  parameter int NPAIR  = 4,
  parameter int DT_W   = 6,
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [mcpwm_pkg::ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [NPAIR-1:0]              pwm_hi,
  output logic [NPAIR-1:0]              pwm_lo,
  output logic                          adc_trig
);
  import mcpwm_pkg::*;
  localparam int NPIN = 2 * NPAIR;

  logic [CNT_W-1:0]            per_sh;
  logic                        center_sh;
  logic [NPAIR-1:0][CNT_W-1:0] duty_sh;
  logic [DT_W-1:0]             dead_q;
  logic [NPAIR-1:0]            indep_q;
  logic [NPIN-1:0]             pol_q;
  logic [NPIN-1:0]             ovr_en_q;
  logic [NPIN-1:0]             ovr_val_q;
  logic [CNT_W-1:0]            trig_cmp_q;
  logic                        trig_down_q;

  logic [CNT_W-1:0]            cnt_q;
  logic                        up_q;
  logic                        center_act;
  logic [CNT_W-1:0]            per_act;
  logic [NPAIR-1:0][CNT_W-1:0] duty_act;

  logic [NPAIR-1:0] raw_v;
  logic [NPAIR-1:0] dt_hi;
  logic [NPAIR-1:0] dt_lo;
  logic [NPIN-1:0]  lvl;
  logic [NPIN-1:0]  pin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_sh      <= '0;
      center_sh   <= 1'b0;
      dead_q      <= '0;
      indep_q     <= '1;
      pol_q       <= '0;
      ovr_en_q    <= '0;
      ovr_val_q   <= '0;
      trig_cmp_q  <= '1;
      trig_down_q <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_PERIOD: per_sh <= wr_data[CNT_W-1:0];
        A_DEAD:   dead_q <= wr_data[DT_W-1:0];
        A_MODE: begin
          center_sh <= wr_data[0];
          indep_q   <= wr_data[NPAIR:1];
        end
        A_POL:    pol_q <= wr_data[NPIN-1:0];
        A_OVR: begin
          ovr_en_q  <= wr_data[NPIN-1:0];
          ovr_val_q <= wr_data[2*NPIN-1:NPIN];
        end
        A_TRIG: begin
          trig_cmp_q  <= wr_data[CNT_W-1:0];
          trig_down_q <= wr_data[DATA_W-1];
        end
        default: ;
      endcase
    end
  end

  mcpwm_timebase #(.CNT_W(CNT_W), .NPAIR(NPAIR)) i_tb (
    .clk(clk), .rst(rst),
    .per_sh(per_sh), .center_sh(center_sh), .duty_sh(duty_sh),
    .cnt_o(cnt_q), .up_o(up_q), .center_o(center_act),
    .per_o(per_act), .duty_o(duty_act)
  );

  generate
    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(DUTY_BASE + g);

      always_ff @(posedge clk) begin
        if (rst)                               duty_sh[g] <= '0;
        else if (wr_en && wr_addr == MY_ADDR)  duty_sh[g] <= wr_data[CNT_W-1:0];
      end

      assign raw_v[g] = cnt_q < duty_act[g];

      mcpwm_deadband #(.DT_W(DT_W)) i_db_hi (
        .clk(clk), .rst(rst), .in_i(raw_v[g]), .dead_i(dead_q), .out_o(dt_hi[g])
      );
      mcpwm_deadband #(.DT_W(DT_W)) i_db_lo (
        .clk(clk), .rst(rst), .in_i(!raw_v[g]), .dead_i(dead_q), .out_o(dt_lo[g])
      );

      assign lvl[g]       = indep_q[g] ? raw_v[g] : dt_hi[g];
      assign lvl[NPAIR+g] = indep_q[g] ? raw_v[g] : dt_lo[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) pin_q <= '0;
    else begin
      for (int k = 0; k < NPIN; k++)
        pin_q[k] <= ovr_en_q[k] ? ovr_val_q[k] : (lvl[k] ^ pol_q[k]);
    end
  end

  assign pwm_hi = pin_q[NPAIR-1:0];
  assign pwm_lo = pin_q[NPIN-1:NPAIR];

  mcpwm_trigger #(.CNT_W(CNT_W)) i_trig (
    .clk(clk), .rst(rst), .cnt_i(cnt_q), .up_i(up_q), .center_i(center_act),
    .cmp_i(trig_cmp_q), .down_sel_i(trig_down_q), .trig_o(adc_trig)
  );
endmodule

// File: rtl/mcpwm_checker.sv
module mcpwm_checker #(
  parameter int CNT_W = 15,
  parameter int NPAIR = 4,
  parameter int DT_W  = 6
) (
  input logic                        clk,
  input logic                        rst,
  input logic [CNT_W-1:0]            cnt_q,
  input logic [CNT_W-1:0]            per_act,
  input logic [NPAIR-1:0][CNT_W-1:0] duty_act,
  input logic [DT_W-1:0]             dead_q,
  input logic [NPAIR-1:0]            raw_v,
  input logic [NPAIR-1:0]            dt_hi,
  input logic [NPAIR-1:0]            dt_lo,
  input logic [2*NPAIR-1:0]          ovr_en_q,
  input logic [2*NPAIR-1:0]          ovr_val_q,
  input logic [CNT_W-1:0]            trig_cmp_q,
  input logic [NPAIR-1:0]            pwm_hi,
  input logic                        adc_trig
);
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= per_act); // R1 R2

  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$stable(duty_act) |-> cnt_q == '0); // R8

  AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (rst)
    adc_trig && per_act != '0 && $past(per_act) != '0 && trig_cmp_q == $past(trig_cmp_q)
    |=> !adc_trig); // R9

  generate
    for (genvar g = 0; g < NPAIR; g++) begin : g_chk
      AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(dt_hi[g] && dt_lo[g])); // R4

      AST_DT_DELAY: assert property (@(posedge clk) disable iff (rst)
        (dead_q != '0) && $rose(dt_hi[g]) |-> $past(raw_v[g])); // R4

      AST_OVR_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        $past(ovr_en_q[g]) |-> pwm_hi[g] == $past(ovr_val_q[g])); // R7
    end
  endgenerate
endmodule

bind mcpwm_core mcpwm_checker #(.CNT_W(CNT_W), .NPAIR(NPAIR), .DT_W(DT_W)) i_chk (
  .clk(clk), .rst(rst), .cnt_q(cnt_q), .per_act(per_act), .duty_act(duty_act),
  .dead_q(dead_q), .raw_v(raw_v), .dt_hi(dt_hi), .dt_lo(dt_lo),
  .ovr_en_q(ovr_en_q), .ovr_val_q(ovr_val_q), .trig_cmp_q(trig_cmp_q),
  .pwm_hi(pwm_hi), .adc_trig(adc_trig)
);

// File: tb/test_mcpwm_core.sv
module test_mcpwm_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  pwm_hi;
  logic [3:0]  pwm_lo;
  logic        adc_trig;

  int total = 0;
  int bad = 0;
  bit done = 0;

  mcpwm_core i_mcpwm_core (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .adc_trig(adc_trig)
  );

  always #4 clk = ~clk;

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  int nh[4];
  int nl[4];
  int nt;

  task automatic measure(int w);
    for (int k = 0; k < 4; k++) begin nh[k] = 0; nl[k] = 0; end
    nt = 0;
    for (int c = 0; c < w; c++) begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
        nh[k] += int'(pwm_hi[k]);
        nl[k] += int'(pwm_lo[k]);
      end
      nt += int'(adc_trig);
    end
  endtask

  function automatic int hi_run(int p, int d, bit c);
    int up;
    int dn;
    up = (d < p + 1) ? d : p + 1;
    if (!c) return up;
    dn = d - 1;
    if (dn > p - 1) dn = p - 1;
    if (dn < 0) dn = 0;
    return up + dn;
  endfunction

  function automatic int dt_run(int n, int len, int dead);
    if (n == 0) return 0;
    if (n == len) return len;
    return (n > dead) ? n - dead : 0;
  endfunction

  initial begin
    int plist[2];
    plist[0] = 4; plist[1] = 7;
    repeat (3) @(negedge clk);
    check("R11 hi in reset", int'(pwm_hi), 0);
    check("R11 lo in reset", int'(pwm_lo), 0);
    check("R11 trig in reset", int'(adc_trig), 0);
    rst = 1'b0;
    measure(20);
    check("R11 hi after reset", nh[0] + nh[1] + nh[2] + nh[3], 0);
    check("R11 lo after reset", nl[0] + nl[1] + nl[2] + nl[3], 0);
    check("R11 trig after reset", nt, 0);

    // near-exhaustive sweep: R1 R2 R3 R4 R5 R6 R9 R10
    for (int pi = 0; pi < 2; pi++) begin
      for (int c = 0; c < 2; c++) begin
        for (int di = 0; di < 2; di++) begin
          for (int ind = 0; ind < 2; ind++) begin
            for (int base = 0; base <= plist[pi] + 1; base++) begin
              int p; int dead; int len; int indpat; int pol; int cmp; int down;
              int duty[4];
              p = plist[pi];
              dead = di * 2;
              len = c ? 2 * p : p + 1;
              indpat = ind ? 5 : 0;
              pol = (base % 2 == 1) ? 8'hA5 : 0;
              cmp = base;
              down = di;
              wr(0, p);
              wr(2, c | (indpat << 1));
              wr(1, dead);
              wr(3, pol);
              wr(5, cmp | (down << 15));
              for (int k = 0; k < 4; k++) begin
                duty[k] = (base + k) % (p + 2);
                wr(8 + k, duty[k]);
              end
              repeat (46) @(negedge clk);
              measure(2 * len);
              for (int k = 0; k < 4; k++) begin
                int hr; int eh; int el;
                hr = hi_run(p, duty[k], c[0]);
                if (indpat[k]) begin
                  eh = hr; el = hr;
                end else begin
                  eh = dt_run(hr, len, dead);
                  el = dt_run(len - hr, len, dead);
                end
                eh *= 2; el *= 2;
                if (pol[k])     eh = 2 * len - eh;
                if (pol[4 + k]) el = 2 * len - el;
                check($sformatf("R1 R2 R3 R4 R5 R6 hi p=%0d c=%0d d=%0d dt=%0d ind=%0d pair=%0d",
                                p, c, duty[k], dead, indpat[k], k), nh[k], eh);
                check($sformatf("R3 R4 R5 R6 lo p=%0d c=%0d d=%0d dt=%0d ind=%0d pair=%0d",
                                p, c, duty[k], dead, indpat[k], k), nl[k], el);
              end
              begin
                int hit;
                if (!c) hit = (cmp <= p) ? 1 : 0;
                else if (down != 0) hit = (cmp >= 1 && cmp <= p - 1) ? 1 : 0;
                else hit = (cmp <= p) ? 1 : 0;
                check($sformatf("R9 R10 trig p=%0d c=%0d cmp=%0d down=%0d", p, c, cmp, down),
                      nt, 2 * hit);
              end
            end
          end
        end
      end
    end

    // R7: override
    wr(0, 4); wr(2, 0); wr(1, 0); wr(3, 8'hFF);
    wr(4, 16'h3CFF);
    repeat (4) @(negedge clk);
    measure(10);
    for (int k = 0; k < 4; k++) begin
      check($sformatf("R7 forced hi pair=%0d", k), nh[k], ((4'hC >> k) & 1) * 10);
      check($sformatf("R7 forced lo pair=%0d", k), nl[k], ((4'h3 >> k) & 1) * 10);
    end
    wr(3, 0);
    for (int k = 0; k < 4; k++) wr(8 + k, 5);
    wr(4, 16'h000F);
    repeat (20) @(negedge clk);
    measure(10);
    check("R7 hi forced low over full duty", nh[0] + nh[1] + nh[2] + nh[3], 0);
    check("R7 lo unforced complementary", nl[0] + nl[1] + nl[2] + nl[3], 0);
    wr(4, 0);

    // R8: duty latched only at zero
    wr(0, 1000); wr(2, 8'h1E); wr(5, 0);
    for (int k = 0; k < 4; k++) wr(8 + k, 0);
    repeat (1100) @(negedge clk);
    begin
      int guard = 0;
      while (!adc_trig && guard < 1200) begin @(negedge clk); guard++; end
      check("R8 trigger seen at zero", int'(adc_trig), 1);
    end
    wr(8, 1001);
    measure(500);
    check("R8 duty held mid period", nh[0], 0);
    repeat (600) @(negedge clk);
    measure(100);
    check("R8 duty applied after zero", nh[0], 100);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule